// File: doc/BRIEF.md
# Two-wire bus start/stop condition control unit

This block sits beside a byte shifter on a two-wire serial bus (clock line SCL, data line SDA). It does two jobs. Software writes one-shot command bits in a small control register to force the serial-output latch that drives SDA, which is how it produces start and stop conditions. The block also watches the bus lines and records what it sees in sticky flags that software reads back from the same register.

The SCL and SDA inputs pass through a chain of synchronizer flops of selectable length. Edges are then detected on the synchronized copies. A start condition is SDA falling while SCL stays high. A stop condition is SDA rising while SCL stays high. The surrounding interface supplies three control inputs:

- an enable level;
- a transfer-start pulse;
- an address-mismatch pulse.

Each detection flag has its own list of events that clear it. Byte shifting, clock generation, address comparison and interrupts belong to neighbouring blocks.

Top module: `sbus_cond_ctl`

## Requirements
- R1: After synchronous reset the register reads 00h and the serial-output latch `sdo_q` is 1.
- R2: Writing a byte with bit 1 (stop command) set, while `en` is 1, makes bit 1 read 1 in the next cycle. One cycle later `sdo_q` is 1 and bit 1 reads 0.
- R3: Writing a byte with bit 0 (start command) set, while `en` is 1, makes bit 0 read 1 in the next cycle. One cycle later `sdo_q` is 0 and bit 0 reads 0.
- R4: When bits 0 and 1 are written as 1 together, the stop command wins and `sdo_q` becomes 1.
- R5: While `en` is 0, writes to both command bits are ignored, the command bits read 0 and `sdo_q` keeps its value.
- R6: Bit 2 (start seen) becomes 1 when SDA falls while SCL is high. An SDA edge while SCL is low sets no flag.
- R7: Bit 3 (stop seen) becomes 1 when SDA rises while SCL is high, and the same event clears bit 2.
- R8: Bit 2 is cleared by a `xfer_start` pulse or by `en` being 0, and is not cleared by `addr_miss`.
- R9: Bit 3 is cleared by a `xfer_start` pulse, by an `addr_miss` pulse or by `en` being 0.
- R10: When a flag's set event and one of its clear events fall in the same cycle, the flag ends at 0.
- R11: Bits 2 and 3 are read-only and bits 7 to 4 always read 0. Writes to these positions leave the read value unchanged.
- R12: A command bit that reads 1 reads 0 in the following cycle unless a new write sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable level |
| xfer_start | input | 1 | One-cycle transfer-start pulse |
| addr_miss | input | 1 | One-cycle address-mismatch pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Register read value |
| scl_raw | input | 1 | Bus clock line, asynchronous |
| sda_raw | input | 1 | Bus data line, asynchronous |
| sdo_q | output | 1 | Serial-output latch driving SDA |

## Verification
SDA is toggled with SCL held high and with SCL held low. This separates true start and stop detection from plain data transitions. Transitions where SCL and SDA move in the same cycle show that a clock edge never counts as a condition. Command writes cover start alone, stop alone, both together and writes with the enable low, which tells the priority rule apart from the self-clearing rule. Clear pulses are timed to hit the exact cycle in which a detection lands, which shows that the clear wins. Random mixes of bus moves, pulses and writes are then checked against a bench model of the flags and the latch.

// File: rtl/sbus_cond_pkg.sv
package sbus_cond_pkg;
  localparam int BIT_START_CMD  = 0;
  localparam int BIT_STOP_CMD   = 1;
  localparam int BIT_START_SEEN = 2;
  localparam int BIT_STOP_SEEN  = 3;
  localparam int STAT_W         = 4;

  typedef struct packed {
    logic stop_seen;
    logic start_seen;
    logic stop_cmd;
    logic start_cmd;
  } cond_stat_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d_in[i]};
    end
    assign d_out[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/sbus_edge_det.sv
module sbus_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // SCL must be high on both samples around the SDA edge
  logic scl_held;
  assign scl_held  = scl_s & scl_d;
  assign start_det = scl_held & sda_d & ~sda_s;
  assign stop_det  = scl_held & ~sda_d & sda_s;
endmodule

// File: rtl/sbus_cmd_unit.sv
module sbus_cmd_unit (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wr_en,
  input  logic wr_start,
  input  logic wr_stop,
  output logic start_cmd,
  output logic stop_cmd,
  output logic sdo_q
);
  logic take;
  assign take = en & wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_cmd <= 1'b0;
      stop_cmd  <= 1'b0;
      sdo_q     <= 1'b1;
    end else begin
      // command bits live for one cycle only
      start_cmd <= take & wr_start;
      stop_cmd  <= take & wr_stop;
      if (stop_cmd)       sdo_q <= 1'b1;
      else if (start_cmd) sdo_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sbus_flag_unit.sv
module sbus_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic xfer_start,
  input  logic addr_miss,
  input  logic start_det,
  input  logic stop_det,
  output logic start_seen,
  output logic stop_seen
);
  logic clr_start, clr_stop;
  assign clr_start = xfer_start | stop_det | ~en;
  assign clr_stop  = xfer_start | addr_miss | ~en;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else begin
      if (clr_start)      start_seen <= 1'b0;
      else if (start_det) start_seen <= 1'b1;
      if (clr_stop)       stop_seen  <= 1'b0;
      else if (stop_det)  stop_seen  <= 1'b1;
    end
  end
endmodule

// File: rtl/sbus_cond_ctl.sv
module sbus_cond_ctl
  import sbus_cond_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             xfer_start,
  input  logic             addr_miss,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             scl_raw,
  input  logic             sda_raw,
  output logic             sdo_q
);
  localparam int PAD_W = REG_W - STAT_W;

  logic [1:0] bus_s;
  logic       start_det, stop_det;
  cond_stat_t stat;

  sbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_in({scl_raw, sda_raw}), .d_out(bus_s)
  );

  sbus_edge_det u_edge (
    .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .start_det(start_det), .stop_det(stop_det)
  );

  sbus_cmd_unit u_cmd (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en),
    .wr_start(wr_data[BIT_START_CMD]), .wr_stop(wr_data[BIT_STOP_CMD]),
    .start_cmd(stat.start_cmd), .stop_cmd(stat.stop_cmd), .sdo_q(sdo_q)
  );

  sbus_flag_unit u_flag (
    .clk(clk), .rst(rst), .en(en), .xfer_start(xfer_start),
    .addr_miss(addr_miss), .start_det(start_det), .stop_det(stop_det),
    .start_seen(stat.start_seen), .stop_seen(stat.stop_seen)
  );

  assign rd_data = {{PAD_W{1'b0}}, stat};
endmodule

// File: rtl/sbus_cond_chk.sv
module sbus_cond_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             xfer_start,
  input logic             addr_miss,
  input logic             wr_en,
  input logic [REG_W-1:0] rd_data,
  input logic             sdo_q,
  input logic             stop_det
);
  p_stop_latch_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] |=> sdo_q);

  p_start_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && !rd_data[1]) |=> !sdo_q);

  p_en_low_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (rd_data[3:0] == 4'b0000));

  p_stop_clears_start_r7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !rd_data[2]);

  p_xfer_clears_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> (rd_data[3:2] == 2'b00));

  p_miss_clears_stop_r9: assert property (@(posedge clk) disable iff (rst)
    addr_miss |=> !rd_data[3]);

  p_cmd_self_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && !wr_en) |=> !rd_data[0]);

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_data[1:0] == 2'b00) |=> $stable(sdo_q));
endmodule

bind sbus_cond_ctl sbus_cond_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .xfer_start(xfer_start),
  .addr_miss(addr_miss), .wr_en(wr_en), .rd_data(rd_data),
  .sdo_q(sdo_q), .stop_det(stop_det)
);

// File: tb/test_sbus_cond_ctl.sv
module test_sbus_cond_ctl;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1, xfer_start = 1'b0, addr_miss = 1'b0, wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic scl_raw = 1'b1, sda_raw = 1'b1;
  logic sdo_q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic m_start = 1'b0, m_stop = 1'b0, m_lat = 1'b1;

  always #2 clk = ~clk;

  sbus_cond_ctl i_sbus_cond_ctl (
    .clk(clk), .rst(rst), .en(en), .xfer_start(xfer_start),
    .addr_miss(addr_miss), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .scl_raw(scl_raw), .sda_raw(sda_raw), .sdo_q(sdo_q)
  );

  function automatic logic [W-1:0] exp_rd(logic st, logic sp);
    return {4'b0000, sp, st, 2'b00};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [W-1:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // move the bus and update the model from the line rules
  task automatic bus(logic scl, logic sda);
    if (scl_raw && scl) begin
      if (sda_raw && !sda) m_start = 1'b1;
      if (!sda_raw && sda) begin m_stop = 1'b1; m_start = 1'b0; end
    end
    scl_raw = scl; sda_raw = sda;
    ticks(4);
  endtask

  task automatic pulse_xfer();
    xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    m_start = 1'b0; m_stop = 1'b0;
  endtask

  task automatic pulse_miss();
    addr_miss = 1'b1; tick(); addr_miss = 1'b0;
    m_stop = 1'b0;
  endtask

  task automatic pulse_en_low();
    en = 1'b0; tick(); en = 1'b1;
    m_start = 1'b0; m_stop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    ticks(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 sdo", {7'b0, sdo_q}, 8'h01);

    // R3 start command, R12 readback
    wr(8'h01);
    chk("R3/R12 cmd visible", rd_data, 8'h01);
    chk("R3 latch not yet", {7'b0, sdo_q}, 8'h01);
    tick();
    chk("R3 latch low", {7'b0, sdo_q}, 8'h00);
    chk("R12 start cmd cleared", rd_data, 8'h00);

    // R2 stop command
    wr(8'h02);
    chk("R2/R12 cmd visible", rd_data, 8'h02);
    tick();
    chk("R2 latch high", {7'b0, sdo_q}, 8'h01);
    chk("R12 stop cmd cleared", rd_data, 8'h00);

    // R4 both together: stop wins
    wr(8'h01); tick();
    chk("R4 pre low", {7'b0, sdo_q}, 8'h00);
    wr(8'h03); tick();
    chk("R4 stop wins", {7'b0, sdo_q}, 8'h01);

    // R5 enable low ignores commands
    en = 1'b0;
    wr(8'h01);
    chk("R5 cmd ignored", rd_data, 8'h00);
    tick();
    chk("R5 latch kept", {7'b0, sdo_q}, 8'h01);
    en = 1'b1;
    m_lat = 1'b1;

    // R6 start detection
    bus(1'b1, 1'b0);
    chk("R6 start seen", rd_data, exp_rd(m_start, m_stop));
    pulse_xfer();
    chk("R8 xfer clears start", rd_data, 8'h00);
    bus(1'b0, 1'b0);
    bus(1'b0, 1'b1);
    bus(1'b0, 1'b0);
    bus(1'b1, 1'b0);
    chk("R6 no flag with SCL low", rd_data, 8'h00);

    // R7 stop detection clears start
    bus(1'b0, 1'b0); bus(1'b0, 1'b1); bus(1'b1, 1'b1); bus(1'b1, 1'b0);
    chk("R7 start before stop", rd_data, 8'h04);
    bus(1'b1, 1'b1);
    chk("R7 stop seen, start cleared", rd_data, 8'h08);

    // R9 address mismatch clears stop only
    bus(1'b1, 1'b0);
    chk("R9 both flags", rd_data, 8'h0C);
    pulse_miss();
    chk("R9/R8 miss clears stop not start", rd_data, 8'h04);
    pulse_en_low();
    chk("R8 en low clears start", rd_data, 8'h00);
    bus(1'b1, 1'b1);
    pulse_xfer();
    chk("R9 xfer clears stop", rd_data, 8'h00);
    bus(1'b1, 1'b0); bus(1'b1, 1'b1);
    pulse_en_low();
    chk("R9 en low clears stop", rd_data, 8'h00);

    // R11 read-only and unused bits
    bus(1'b1, 1'b0);
    wr(8'hF0); tick();
    chk("R11 upper bits read 0", rd_data, 8'h04);
    wr(8'h08); tick();
    chk("R11 flag bits not writable", rd_data, 8'h04);
    pulse_xfer();

    // R10 clear in the same cycle as a start detection
    scl_raw = 1'b1; sda_raw = 1'b1; ticks(4);
    sda_raw = 1'b0;
    ticks(2);
    xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    ticks(2);
    chk("R10 start clear wins", rd_data, 8'h00);
    // R10 stop detection meets address mismatch
    sda_raw = 1'b1;
    ticks(2);
    addr_miss = 1'b1; tick(); addr_miss = 1'b0;
    ticks(2);
    chk("R10 stop clear wins", rd_data, 8'h00);
    m_start = 1'b0; m_stop = 1'b0;

    // random mix against the model
    for (int it = 0; it < 400; it++) begin
      int act;
      act = int'($urandom_range(0, 7));
      case (act)
        0, 1, 2: bus(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        3: pulse_xfer();
        4: pulse_miss();
        5: pulse_en_low();
        default: begin
          logic [W-1:0] d;
          d = W'($urandom);
          if (d[1]) m_lat = 1'b1;
          else if (d[0]) m_lat = 1'b0;
          wr(d);
          ticks(3);
          chk("R2/R3/R4 random latch", {7'b0, sdo_q}, {7'b0, m_lat});
        end
      endcase
      chk("R6/R7/R8/R9 random flags", rd_data, exp_rd(m_start, m_stop));
    end

    finish_run();
  end
endmodule